// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Three-State Pad Control

This block is the serial chain of test cells that sits between a device's pads and its core logic. Every position in the chain holds a capture stage and an update stage. The capture stage takes part in a serial shift path from `scan_in` to `scan_out`. The update stage holds the value the cell presents while test mode is active. Each position has one of four kinds, chosen by a parameter. An input cell observes a pad and feeds the core. A two-state output cell drives a pad that is always enabled. A three-state output cell drives a pad whose enable can be switched off. A control cell holds the enable decision for one or more three-state outputs.

An external test-port controller drives the capture, shift and update strobes as clock enables in the single test-clock domain. Capture and shift act on the rising edge. Update acts on the falling edge, so the pad-side values change half a cycle after the update strobe is raised. When `test_mode` is low every cell is transparent and the core and pads see each other directly. When `test_mode` is high the pads and the core inputs take their values from the update stages. Each three-state output is floated when its assigned control cell holds that output's own disable value.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, every capture stage clears to 0, every update stage reloads its safe value, and the cells behave as in normal mode whatever `test_mode` is. In the default configuration the safe values are 1 in cells 3 and 5 and 0 elsewhere.
- R2: On a rising edge with `capture_en` high and `shift_en` low, each capture stage loads its parallel input. That input is `pad_in[i]` for an input cell, `core_val[i]` for a two- or three-state output cell, and `core_oe[i]` for a control cell.
- R3: On a rising edge with `shift_en` high, cell i loads the capture value of cell i+1 and the highest cell loads `scan_in`. `scan_out` always shows cell 0's capture stage. Shift takes precedence over capture. With both strobes low, the capture stages hold their values.
- R4: After N_CELLS shifts, the first bit entered sits in cell 0 (the `scan_out` end) and the last bit entered sits in cell N_CELLS-1.
- R5: On a falling edge with `update_en` high, every update stage copies its capture stage. The capture stages are not disturbed.
- R6: With `test_mode` low, `core_in[i]` equals `pad_in[i]` for input cells. `pad_val[i]` equals `core_val[i]` for output cells. `pad_oe[i]` equals `core_oe[i]` for three-state cells.
- R7: With `test_mode` high, `core_in[i]` of an input cell and `pad_val[i]` of an output cell equal that cell's own update stage.
- R8: With `test_mode` high, `pad_oe[i]` of a three-state cell is 0 exactly when the update stage of its assigned control cell equals that output's disable value. In the default layout, cell 0 controls cell 1 (disable value 0) and cell 2 (disable value 1), and cell 7 controls cell 6 (disable value 0).
- R9: Input and control cells drive 0 on `pad_val` and `pad_oe`. Two-state output cells keep `pad_oe` at 1. Non-input cells drive 0 on `core_in`. The default layout, listed from cell 0 to cell 7, is: control, three-state, three-state, two-state, input, input, three-state, control.
- R10: While `update_en` stays low, the update stages keep their values. Test-mode pad and core values therefore stay fixed during capture and shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture/shift on rising edge, update on falling edge |
| rst_n | input | 1 | Asynchronous active-low test reset |
| capture_en | input | 1 | Capture strobe (clock enable) |
| shift_en | input | 1 | Shift strobe (clock enable), wins over capture |
| update_en | input | 1 | Update strobe, sampled on the falling edge |
| test_mode | input | 1 | 0 = transparent, 1 = cells drive from update stages |
| scan_in | input | 1 | Serial input into the highest-numbered cell |
| core_val | input | N_CELLS | Core output values, one per cell position |
| core_oe | input | N_CELLS | Core output enables, one per cell position |
| pad_in | input | N_CELLS | Values received at input pads |
| scan_out | output | 1 | Serial output from cell 0 |
| pad_val | output | N_CELLS | Values driven toward output pads |
| pad_oe | output | N_CELLS | Pad drive enables (0 = high impedance) |
| core_in | output | N_CELLS | Values passed to the core from input cells |

## Verification
The pad and core outputs are combinational in `test_mode` and in the inputs. The bench checks them two time units after it changes any input, within the same cycle. A capture or shift result appears on `scan_out` one rising edge after the strobe is raised, so the bench checks it just after that edge. An update lands on the falling edge in the middle of the cycle in which `update_en` is high, so the bench checks the pads just after that falling edge. The bench holds `update_en` until the next rising edge, and it keeps a reference model of both stage arrays that advances on the same edges.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    // Cell kind encoding used by the CELL_KIND parameter of the chain.
    localparam logic [1:0] KIND_IN   = 2'd0;  // observes a pad, feeds the core
    localparam logic [1:0] KIND_OUT2 = 2'd1;  // drives an always-enabled pad
    localparam logic [1:0] KIND_OUT3 = 2'd2;  // drives a pad with switchable enable
    localparam logic [1:0] KIND_CTRL = 2'd3;  // holds an enable decision
endpackage

// File: rtl/bscan_capture_chain.sv
module bscan_capture_chain #(
    parameter int N_CELLS = 8
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] par_in,
    output logic [N_CELLS-1:0] cap_q,
    output logic               scan_out
);
    typedef struct packed {
        logic [N_CELLS-1:0] cap;
    } cap_state_t;

    cap_state_t st_d, st_q;

    // Shift moves data toward cell 0; capture loads the parallel inputs.
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.cap = {scan_in, st_q.cap[N_CELLS-1:1]};
        end else if (capture_en) begin
            st_d.cap = par_in;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_q    = st_q.cap;
    assign scan_out = st_q.cap[0];
endmodule

// File: rtl/bscan_update_bank.sv
module bscan_update_bank #(
    parameter int                 N_CELLS  = 8,
    parameter logic [N_CELLS-1:0] SAFE_VAL = '0
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               update_en,
    input  logic [N_CELLS-1:0] cap_in,
    output logic [N_CELLS-1:0] upd_q
);
    typedef struct packed {
        logic [N_CELLS-1:0] upd;
    } upd_state_t;

    upd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update_en) begin
            st_d.upd = cap_in;
        end
    end

    // Falling-edge register: pad-side values move half a cycle after the strobe.
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            st_q.upd <= SAFE_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_q = st_q.upd;
endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
    import bscan_pkg::*;
#(
    parameter int                              N_CELLS   = 8,
    parameter int                              IDX_W     = 3,
    parameter logic [N_CELLS-1:0][1:0]         CELL_KIND = '0,
    parameter logic [N_CELLS-1:0][IDX_W-1:0]   CTRL_SEL  = '0,
    parameter logic [N_CELLS-1:0]              DIS_VAL   = '0
) (
    input  logic               mode,
    input  logic [N_CELLS-1:0] upd,
    input  logic [N_CELLS-1:0] pad_in,
    input  logic [N_CELLS-1:0] core_val,
    input  logic [N_CELLS-1:0] core_oe,
    output logic [N_CELLS-1:0] par_in,
    output logic [N_CELLS-1:0] core_in,
    output logic [N_CELLS-1:0] pad_val,
    output logic [N_CELLS-1:0] pad_oe
);
    always_comb begin
        for (int i = 0; i < N_CELLS; i++) begin
            par_in[i]  = 1'b0;
            core_in[i] = 1'b0;
            pad_val[i] = 1'b0;
            pad_oe[i]  = 1'b0;
            case (CELL_KIND[i])
                KIND_IN: begin
                    par_in[i]  = pad_in[i];
                    core_in[i] = mode ? upd[i] : pad_in[i];
                end
                KIND_OUT2: begin
                    par_in[i]  = core_val[i];
                    pad_val[i] = mode ? upd[i] : core_val[i];
                    pad_oe[i]  = 1'b1;
                end
                KIND_OUT3: begin
                    par_in[i]  = core_val[i];
                    pad_val[i] = mode ? upd[i] : core_val[i];
                    pad_oe[i]  = mode ? (upd[CTRL_SEL[i]] != DIS_VAL[i]) : core_oe[i];
                end
                default: begin
                    // control cell: observes the core enable, drives nothing
                    par_in[i] = core_oe[i];
                end
            endcase
        end
    end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int                            N_CELLS   = 8,
    parameter int                            IDX_W     = 3,
    // Index 0 is the scan_out end of the chain.
    parameter logic [N_CELLS-1:0][1:0]       CELL_KIND = {KIND_CTRL, KIND_OUT3, KIND_IN,  KIND_IN,
                                                          KIND_OUT2, KIND_OUT3, KIND_OUT3, KIND_CTRL},
    parameter logic [N_CELLS-1:0][IDX_W-1:0] CTRL_SEL  = {3'd0, 3'd7, 3'd0, 3'd0,
                                                          3'd0, 3'd0, 3'd0, 3'd0},
    parameter logic [N_CELLS-1:0]            DIS_VAL   = 8'b0000_0100,
    parameter logic [N_CELLS-1:0]            SAFE_VAL  = 8'b0010_1000
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               test_mode,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] core_val,
    input  logic [N_CELLS-1:0] core_oe,
    input  logic [N_CELLS-1:0] pad_in,
    output logic               scan_out,
    output logic [N_CELLS-1:0] pad_val,
    output logic [N_CELLS-1:0] pad_oe,
    output logic [N_CELLS-1:0] core_in
);
    logic               mode_eff;
    logic [N_CELLS-1:0] par_in;
    logic [N_CELLS-1:0] cap_q;
    logic [N_CELLS-1:0] upd_q;

    // Test mode is held off for as long as reset is applied.
    assign mode_eff = test_mode & rst_n;

    bscan_capture_chain #(
        .N_CELLS (N_CELLS)
    ) u_cap (
        .tck        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .scan_in    (scan_in),
        .par_in     (par_in),
        .cap_q      (cap_q),
        .scan_out   (scan_out)
    );

    bscan_update_bank #(
        .N_CELLS  (N_CELLS),
        .SAFE_VAL (SAFE_VAL)
    ) u_upd (
        .tck       (tck),
        .rst_n     (rst_n),
        .update_en (update_en),
        .cap_in    (cap_q),
        .upd_q     (upd_q)
    );

    bscan_pad_mux #(
        .N_CELLS   (N_CELLS),
        .IDX_W     (IDX_W),
        .CELL_KIND (CELL_KIND),
        .CTRL_SEL  (CTRL_SEL),
        .DIS_VAL   (DIS_VAL)
    ) u_mux (
        .mode     (mode_eff),
        .upd      (upd_q),
        .pad_in   (pad_in),
        .core_val (core_val),
        .core_oe  (core_oe),
        .par_in   (par_in),
        .core_in  (core_in),
        .pad_val  (pad_val),
        .pad_oe   (pad_oe)
    );
endmodule

// File: rtl/bscan_chain_checker.sv
module bscan_chain_checker
    import bscan_pkg::*;
#(
    parameter int                      N_CELLS   = 8,
    parameter logic [N_CELLS-1:0][1:0] CELL_KIND = '0
) (
    input logic               tck,
    input logic               rst_n,
    input logic               capture_en,
    input logic               shift_en,
    input logic               update_en,
    input logic               test_mode,
    input logic [N_CELLS-1:0] core_val,
    input logic [N_CELLS-1:0] pad_in,
    input logic               scan_out,
    input logic [N_CELLS-1:0] pad_val,
    input logic [N_CELLS-1:0] pad_oe,
    input logic [N_CELLS-1:0] core_in
);
    function automatic logic [N_CELLS-1:0] kind_mask(input logic [1:0] k);
        logic [N_CELLS-1:0] m;
        for (int i = 0; i < N_CELLS; i++) begin
            m[i] = (CELL_KIND[i] == k);
        end
        return m;
    endfunction

    localparam logic [N_CELLS-1:0] IN_M   = kind_mask(KIND_IN);
    localparam logic [N_CELLS-1:0] OUT2_M = kind_mask(KIND_OUT2);
    localparam logic [N_CELLS-1:0] OUT_M  = kind_mask(KIND_OUT2) | kind_mask(KIND_OUT3);

    // R1: reset forces normal-mode transparency for input cells
    p_reset_transparent_r1: assert property (@(posedge tck)
        !rst_n |-> (core_in == (pad_in & IN_M)));

    // R3: with no capture or shift, scan_out holds
    p_scan_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (!shift_en && !capture_en) |=> $stable(scan_out));

    // R6: normal mode passes pads and core straight through
    p_normal_pass_r6: assert property (@(posedge tck) disable iff (!rst_n)
        !test_mode |-> ((pad_val == (core_val & OUT_M)) && (core_in == (pad_in & IN_M))));

    // R9: only output cells enable a pad; two-state outputs always enabled
    p_pad_drive_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (((pad_oe & ~OUT_M) == '0) && ((pad_oe & OUT2_M) == OUT2_M)));

    // R10: no update strobe in the cycle keeps test-mode pad values fixed
    p_hold_pads_r10: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(rst_n) && test_mode && $past(test_mode) && !update_en) |-> $stable(pad_val));
endmodule

bind bscan_chain bscan_chain_checker #(
    .N_CELLS   (N_CELLS),
    .CELL_KIND (CELL_KIND)
) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .test_mode  (test_mode),
    .core_val   (core_val),
    .pad_in     (pad_in),
    .scan_out   (scan_out),
    .pad_val    (pad_val),
    .pad_oe     (pad_oe),
    .core_in    (core_in)
);

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;
    localparam int N = 8;
    // Bench's own copy of the default layout (cell 0 first).
    localparam int KIND [N] = '{3, 2, 2, 1, 0, 0, 2, 3};  // 0 in,1 out2,2 out3,3 ctrl
    localparam int CSEL [N] = '{0, 0, 0, 0, 0, 0, 7, 0};
    localparam logic [N-1:0] DIS  = 8'b0000_0100;
    localparam logic [N-1:0] SAFE = 8'b0010_1000;

    logic tck = 1'b0;
    logic rst_n, capture_en, shift_en, update_en, test_mode, scan_in;
    logic [N-1:0] core_val, core_oe, pad_in;
    logic scan_out;
    logic [N-1:0] pad_val, pad_oe, core_in;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    logic [N-1:0] m_cap, m_upd;
    logic [N-1:0] e_core, e_pv, e_oe;

    // 50 MHz: 20 ns period
    always #10 tck = ~tck;

    bscan_chain dut (
        .tck(tck), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .test_mode(test_mode), .scan_in(scan_in),
        .core_val(core_val), .core_oe(core_oe), .pad_in(pad_in),
        .scan_out(scan_out), .pad_val(pad_val), .pad_oe(pad_oe), .core_in(core_in)
    );

    function automatic logic [N-1:0] exp_par();
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) begin
            case (KIND[i])
                0:       p[i] = pad_in[i];
                1, 2:    p[i] = core_val[i];
                default: p[i] = core_oe[i];
            endcase
        end
        return p;
    endfunction

    task automatic compute_exp();
        logic md;
        md = test_mode && rst_n;
        e_core = '0; e_pv = '0; e_oe = '0;
        for (int i = 0; i < N; i++) begin
            case (KIND[i])
                0: e_core[i] = md ? m_upd[i] : pad_in[i];
                1: begin
                    e_pv[i] = md ? m_upd[i] : core_val[i];
                    e_oe[i] = 1'b1;
                end
                2: begin
                    e_pv[i] = md ? m_upd[i] : core_val[i];
                    e_oe[i] = md ? (m_upd[CSEL[i]] != DIS[i]) : core_oe[i];
                end
                default: ;
            endcase
        end
    endtask

    task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        compute_exp();
        chk(tag, "core_in", core_in, e_core);
        chk(tag, "pad_val", pad_val, e_pv);
        chk(tag, "pad_oe", pad_oe, e_oe);
        chk(tag, "scan_out", {7'd0, scan_out}, {7'd0, m_cap[0]});
    endtask

    task automatic rnd_inputs();
        pad_in   = N'($urandom);
        core_val = N'($urandom);
        core_oe  = N'($urandom);
    endtask

    task automatic next_edge();
        @(posedge tck);
        #1;
    endtask

    // All operations start and end 1 unit after a rising edge.
    task automatic op_capture();
        rnd_inputs();
        capture_en = 1'b1;
        #2 check_all(test_mode ? "R7" : "R6");
        @(posedge tck);
        m_cap = exp_par();
        #1 capture_en = 1'b0;
        #1 check_all("R2");
    endtask

    task automatic op_shift(int nbits, logic [N-1:0] bits, bit with_cap);
        for (int j = 0; j < nbits; j++) begin
            scan_in = bits[j];
            shift_en = 1'b1;
            capture_en = with_cap;
            #2 check_all("R3");
            @(posedge tck);
            m_cap = {scan_in, m_cap[N-1:1]};
            #1;
        end
        shift_en = 1'b0;
        capture_en = 1'b0;
        #1 check_all("R3 R10");
    endtask

    task automatic op_update();
        update_en = 1'b1;
        @(negedge tck);
        m_upd = m_cap;
        #1 check_all("R5 R7 R8");
        @(posedge tck);
        #1 update_en = 1'b0;
        check_all("R5");
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; capture_en = 0; shift_en = 0; update_en = 0;
        test_mode = 1'b1; scan_in = 0;
        core_val = 8'hA5; core_oe = 8'h3C; pad_in = 8'h96;
        m_cap = '0; m_upd = SAFE;
        #3 check_all("R1 reset");
        next_edge();
        next_edge();
        rst_n = 1'b1;
        #1 check_all("R1 safe");

        // R4: first bit ends in cell 0 (control for cells 1 and 2)
        op_shift(N, 8'b0000_0001, 1'b0);
        op_update();
        chk("R4 R8", "pad_oe[2:1]", {6'd0, pad_oe[2:1]}, 8'b0000_0001);
        op_shift(N, 8'b1111_1110, 1'b0);
        op_update();
        chk("R4 R8", "pad_oe[2:1]", {6'd0, pad_oe[2:1]}, 8'b0000_0010);

        // R3: shift wins when both strobes are high
        op_capture();
        op_shift(3, 8'b0000_0101, 1'b1);

        // R10: shifting and capturing without update leaves pads fixed
        op_update();
        op_capture();
        op_shift(N, N'($urandom), 1'b0);

        // Mixed random operations
        for (int it = 0; it < 400; it++) begin
            case ($urandom % 6)
                0: op_capture();
                1: op_shift(1 + int'($urandom % N), N'($urandom), $urandom % 2 == 1);
                2: op_update();
                3: begin
                    test_mode = ~test_mode;
                    #2 check_all(test_mode ? "R7 R8" : "R6");
                    next_edge();
                end
                4: begin
                    rnd_inputs();
                    #2 check_all(test_mode ? "R10 R9" : "R6 R9");
                    next_edge();
                    check_all("R3 hold");
                end
                default: begin
                    if ($urandom % 8 == 0) begin
                        rst_n = 1'b0;
                        m_cap = '0;
                        m_upd = SAFE;
                        #2 check_all("R1");
                        next_edge();
                        rst_n = 1'b1;
                        #1 check_all("R1 release");
                    end else begin
                        next_edge();
                        check_all("R9");
                    end
                end
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule